// File: doc/BRIEF.md
# N-Chance Clock Replacement Victim Selector

This block picks which physical frame to evict when a new page must be brought in. For a fixed number of frames it keeps one referenced flag and one small age counter per frame. Outside logic reports every use of a frame on the access inputs, and that sets the frame's referenced flag.

When a victim is wanted, a request pulse starts a sweep. A circular hand examines one frame per clock. A referenced frame loses its flag and gains age credit. An unreferenced frame with credit left loses one unit of credit. The first unreferenced frame with no credit is named as the victim.

The chosen frame is then treated as freshly loaded: its flag is set and its credit is cleared. The hand moves past it, so the next sweep starts at the following frame. A frame used often between sweeps therefore survives several passes of the hand instead of just one. Frame count and counter width are parameters.

Top module: `clockVictimSel`

## Requirements
- R1: After reset the block is idle (`busy` low, `victimValid` low). The hand points at frame 0 and every referenced flag and counter is 0, so the first request names frame 0 in its first sweep cycle.
- R2: A `findReq` seen while idle makes `busy` high from the next cycle. While busy, the hand examines exactly one frame per cycle and steps from frame NUM_FRAMES-1 back to frame 0. While idle, the hand holds still.
- R3: When the examined frame has its referenced flag set, the flag is cleared, the frame's counter goes up by one and the hand advances.
- R4: When the examined frame has its flag clear and its counter at 0, `victimValid` is high in that same cycle with `victimFrame` equal to that frame. `busy` is low from the next cycle.
- R5: When the examined frame has its flag clear and a non-zero counter, the counter goes down by one and the hand advances without naming a victim.
- R6: After a victim is named, the hand points at the following frame. The victim's flag is set and its counter is 0.
- R7: A counter already at its maximum (2^CNT_W-1) stays at its maximum when the hand finds the frame referenced; it does not wrap to 0.
- R8: An access (`accValid` with `accFrame`) sets that frame's referenced flag in any cycle, idle or busy. If it falls in the cycle in which the hand clears that frame's flag, the flag stays set. The sweep's effect on the counter in that cycle is unchanged.
- R9: A `findReq` raised while a sweep is in progress is ignored: it neither restarts nor extends the sweep, and it is not queued.
- R10: `victimValid` is high only while `busy` is high, for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | A frame was used this cycle |
| accFrame | input | IDX_W | Index of the used frame |
| findReq | input | 1 | Request a victim (taken only while idle) |
| busy | output | 1 | Sweep in progress |
| victimValid | output | 1 | Victim found this cycle |
| victimFrame | output | IDX_W | Index of the victim frame, valid with `victimValid` |

## Verification
The bench builds the block with four frames and a one-bit counter. With only two counter values, two referenced visits in a row drive a counter into saturation within a single sweep. A wrapping counter would then expose itself on the next request by a different victim.

Four frames also keep the worst sweep short: one clearing pass, one draining pass and one final step. This lets the hand's wrap from the last frame to frame 0, the victim's own reload and the latency of every sweep be worked out by hand for each table row.

Accesses are timed to land on exact sweep cycles. One lands on the cycle the hand is clearing that same frame. Another lands on a cycle where the frame's counter is being decremented. Extra requests are injected mid-sweep.

// File: rtl/clockSelPkg.sv
package clockSelPkg;

  // Strobes from the sweep control to the frame state, one per sweep cycle.
  typedef struct packed {
    logic clrAcc;  // referenced frame: drop its flag
    logic incCnt;  // referenced frame: add age credit (saturating)
    logic decCnt;  // unreferenced frame with credit: spend one unit
    logic claim;   // unreferenced frame without credit: it is the victim
  } sweepCmd_t;

endpackage

// File: rtl/clockSelDatapath.sv
module clockSelDatapath
  import clockSelPkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int CNT_W      = 2,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accValid,
  input  logic [IDX_W-1:0] accFrame,
  input  logic [IDX_W-1:0] hand,
  input  sweepCmd_t        cmd,
  output logic             curAcc,
  output logic             curCntZero
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_FRAMES-1:0] accBits;
  logic [NUM_FRAMES-1:0] cntZero;

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : gen_frame
    logic             accQ;
    logic [CNT_W-1:0] cntQ;
    logic             sel;
    logic             hit;

    assign sel = (hand == IDX_W'(i));
    assign hit = accValid && (accFrame == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        accQ <= 1'b0;
        cntQ <= '0;
      end else if (sel && cmd.claim) begin
        // freshly loaded page: in use, no credit yet
        accQ <= 1'b1;
        cntQ <= '0;
      end else begin
        // an access wins over the sweep clearing the flag
        if (hit) begin
          accQ <= 1'b1;
        end else if (sel && cmd.clrAcc) begin
          accQ <= 1'b0;
        end
        if (sel && cmd.incCnt && (cntQ != CNT_MAX)) begin
          cntQ <= cntQ + 1'b1;
        end else if (sel && cmd.decCnt) begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end

    assign accBits[i] = accQ;
    assign cntZero[i] = (cntQ == '0);
  end

  assign curAcc     = accBits[hand];
  assign curCntZero = cntZero[hand];

endmodule

// File: rtl/clockSelCtrl.sv
module clockSelCtrl
  import clockSelPkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             findReq,
  input  logic             curAcc,
  input  logic             curCntZero,
  output sweepCmd_t        cmd,
  output logic [IDX_W-1:0] hand,
  output logic             busy,
  output logic             victimValid
);

  localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(NUM_FRAMES - 1);

  // decide what the hand does with the frame under it
  always_comb begin
    cmd = '0;
    if (busy) begin
      if (curAcc) begin
        cmd.clrAcc = 1'b1;
        cmd.incCnt = 1'b1;
      end else if (curCntZero) begin
        cmd.claim = 1'b1;
      end else begin
        cmd.decCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hand <= '0;
    end else if (busy) begin
      hand <= (hand == LAST_FRAME) ? '0 : hand + 1'b1;
      if (cmd.claim) begin
        busy <= 1'b0;
      end
    end else if (findReq) begin
      busy <= 1'b1;
    end
  end

  assign victimValid = cmd.claim;

endmodule

// File: rtl/clockVictimSel.sv
module clockVictimSel
  import clockSelPkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int CNT_W      = 2,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accValid,
  input  logic [IDX_W-1:0] accFrame,
  input  logic             findReq,
  output logic             busy,
  output logic             victimValid,
  output logic [IDX_W-1:0] victimFrame
);

  sweepCmd_t        cmd;
  logic [IDX_W-1:0] hand;
  logic             curAcc;
  logic             curCntZero;

  clockSelCtrl #(
    .NUM_FRAMES(NUM_FRAMES),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .findReq    (findReq),
    .curAcc     (curAcc),
    .curCntZero (curCntZero),
    .cmd        (cmd),
    .hand       (hand),
    .busy       (busy),
    .victimValid(victimValid)
  );

  clockSelDatapath #(
    .NUM_FRAMES(NUM_FRAMES),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accValid  (accValid),
    .accFrame  (accFrame),
    .hand      (hand),
    .cmd       (cmd),
    .curAcc    (curAcc),
    .curCntZero(curCntZero)
  );

  assign victimFrame = hand;

endmodule

// File: rtl/clockVictimSelChecker.sv
module clockVictimSelChecker #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             findReq,
  input logic             busy,
  input logic             victimValid,
  input logic [IDX_W-1:0] hand
);

  localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(NUM_FRAMES - 1);

  // R10: a victim is only reported inside a sweep
  assert_victim_in_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> busy);

  // R4: the sweep ends right after the victim cycle
  assert_idle_after_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |=> !busy);

  // R2: an idle request starts a sweep
  assert_start_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && findReq) |=> busy);

  // R9: a sweep without a victim keeps going, whatever findReq does
  assert_sweep_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !victimValid) |=> busy);

  // R2: one frame per busy cycle, wrapping after the last frame
  assert_hand_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (hand == (($past(hand) == LAST_FRAME) ? '0 : $past(hand) + 1'b1)));

  // R2: the hand rests while idle
  assert_hand_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(hand));

endmodule

bind clockVictimSel clockVictimSelChecker #(
  .NUM_FRAMES(NUM_FRAMES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .findReq    (findReq),
  .busy       (busy),
  .victimValid(victimValid),
  .hand       (hand)
);

// File: tb/clockVictimSel_bench.sv
module clockVictimSel_bench;

  localparam int N     = 4;
  localparam int CW    = 1;
  localparam int IW    = 2;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          accValid = 1'b0;
  logic [IW-1:0] accFrame = '0;
  logic          findReq = 1'b0;
  logic          busy;
  logic          victimValid;
  logic [IW-1:0] victimFrame;

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;

  always #4 clk = ~clk;  // 125 MHz

  clockVictimSel #(.NUM_FRAMES(N), .CNT_W(CW)) u_clockVictimSel (
    .clk        (clk),
    .rst_n      (rst_n),
    .accValid   (accValid),
    .accFrame   (accFrame),
    .findReq    (findReq),
    .busy       (busy),
    .victimValid(victimValid),
    .victimFrame(victimFrame)
  );

  // accFirst/accLast: sweep cycles with an access (0 = the request cycle)
  // reqAt: sweep cycle with an extra findReq (0 = none)
  typedef struct packed {
    int accEn;
    int accFrm;
    int accFirst;
    int accLast;
    int reqAt;
    int expVictim;
    int expLat;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{0, 0, 0, 0, 0, 0, 1},  // R1 R4: empty state, frame 0 at once
    '{0, 0, 0, 0, 0, 1, 1},  // R6: hand moved on
    '{0, 0, 0, 0, 0, 2, 1},
    '{0, 0, 0, 0, 0, 3, 1},  // all flags now set by reloads
    '{1, 1, 2, 2, 0, 0, 9},  // R3 R5 R8 R2: access on the clearing cycle
    '{0, 0, 0, 0, 0, 2, 2},  // R7: frame 1 kept credit 1 (saturated)
    '{1, 3, 0, 0, 0, 1, 3},  // R8: idle access protects frame 3
    '{0, 0, 0, 0, 3, 3, 6},  // R9 R5: extra request mid sweep
    '{0, 0, 0, 0, 0, 0, 1},
    '{1, 1, 1, 1, 0, 2, 2},  // R8 R5: access while credit is spent
    '{0, 0, 0, 0, 4, 3, 9}   // R9 R2: full clear and drain, wrap
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runSweep(input vec_t v, output int vic, output int lat);
    @(negedge clk);
    findReq  = 1'b1;
    accValid = (v.accEn != 0) && (v.accFirst == 0);
    accFrame = IW'(v.accFrm);
    @(posedge clk);
    vic = -1;
    lat = 0;
    for (int cyc = 1; cyc <= 40 && lat == 0; cyc++) begin
      @(negedge clk);
      findReq  = (v.reqAt == cyc);
      accValid = (v.accEn != 0) && (cyc >= v.accFirst) && (cyc <= v.accLast);
      if (victimValid) begin
        lat = cyc;
        vic = int'(victimFrame);
      end
      if (lat == 0) @(posedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    findReq  = 1'b0;
    accValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount == WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycleCount);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int vic;
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(victimValid == 1'b0, "R1 victimValid after reset", int'(victimValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R2 idle without request", int'(busy), 0);

    for (int r = 0; r < 11; r++) begin
      runSweep(VECS[r], vic, lat);
      chk(vic == VECS[r].expVictim, $sformatf("R4 R6 R7 row %0d victim", r), vic, VECS[r].expVictim);
      chk(lat == VECS[r].expLat, $sformatf("R2 R3 R5 R8 row %0d latency", r), lat, VECS[r].expLat);
      chk(busy == 1'b0, $sformatf("R9 R10 row %0d idle after victim", r), int'(busy), 0);
    end

    // R1: reset in the middle of a long sweep
    for (int f = 0; f < N; f++) begin
      @(negedge clk);
      accValid = 1'b1;
      accFrame = IW'(f);
    end
    @(negedge clk);
    accValid = 1'b0;
    findReq  = 1'b1;
    @(negedge clk);
    findReq = 1'b0;
    chk(busy == 1'b1, "R2 sweep started", int'(busy), 1);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy == 1'b0, "R1 reset stops sweep", int'(busy), 0);
    chk(victimValid == 1'b0, "R1 no victim in reset", int'(victimValid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    runSweep(VECS[0], vic, lat);
    chk(vic == 0, "R1 victim after reset", vic, 0);
    chk(lat == 1, "R1 latency after reset", lat, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule